// File: doc/BRIEF.md
# Output-Compare PWM with Fault Control

This block is a timer-driven output-compare unit that produces an edge-aligned PWM waveform. A base timer counts from zero up to a programmed period and then wraps. The output is high while the count is below a programmed duty value. A fine-duty field places the falling edge within the duty-match count in quarter steps, so the edge can land on any of four sub-phases. Inside the block, every base-timer count is four clock cycles long, and those four clock cycles are the four sub-phases.

The fault input forces the output to a fixed level. There are two ways to leave the fault state. In the first, the fault ends at the next period wrap once the fault input has gone quiet. In the second, the fault input must be quiet and software must pulse an acknowledge strobe. The output can be inverted. The output enable can be switched off (tristated), and a fault can optionally force the enable back on.

The base timer has two control modes. In trigger mode, the timer is held at zero until a trigger event arrives, and a running flag is then set by hardware. In sync mode, an external sync pulse restarts the timer. In PWM mode, the period, duty and fine-duty values are double-buffered and take effect at the next period wrap. In the other mode they take effect at once.

Top module: `oc_pwm`

## Requirements
- R1: While no sync, hold or fault applies, the timer advances by one every 4 clock cycles. It counts 0..P, where P is the active period (written at address 0), and then wraps to 0. One PWM period is therefore 4*(P+1) clock cycles.
- R2: The output, before inversion, is high while the count is below the active duty D (written at address 1) and low from D on. D=0 gives a constantly low output. D>=P gives a constantly high output. The output register adds one clock of latency.
- R3: The fine-duty field F (address 2, bits 1:0) keeps the output high for F of the 4 sub-phases of the count equal to D. F=0 makes the output fall at the start of that count.
- R4: Control bit 0 (address 3) selects PWM mode. When it is 1, a new period, duty or fine value is used only from the next wrap. When it is 0, a new value is used from the clock after the write.
- R5: Control bit 4 set to 1 inverts the compare output. It does not invert the fault level.
- R6: One clock after the fault input is high, the fault state is active. While the fault state is active, the output equals control bit 2.
- R7: With control bit 1 at 0, the fault state clears at the first period wrap at which the fault input is low.
- R8: With control bit 1 at 1, the fault state clears only on a fault-clear strobe that arrives while the fault input is low. A strobe that arrives while the fault input is high has no effect.
- R9: Control bit 5 set to 1 drives the output enable low. During a fault, control bit 3 set to 1 forces the output enable high. With bit 3 at 0, a fault leaves the enable as it is.
- R10: With control bit 6 at 1, the timer is held at zero and the output stays low (before inversion) until a trigger pulse arrives. The trigger pulse sets the running flag, and the timer then counts.
- R11: A control write with bit 7 set clears the running flag, which re-arms the trigger. A trigger in the same clock cycle wins over the clear.
- R12: With control bit 6 at 0, a sync pulse resets both the timer and the sub-phase to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the sub-phase rate |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 period, 1 duty, 2 fine duty, 3 control |
| wrData | input | CNT_W | Write data |
| faultIn | input | 1 | Fault request, active high |
| faultClr | input | 1 | Software fault acknowledge strobe |
| syncIn | input | 1 | Timer sync pulse |
| trigIn | input | 1 | Timer trigger pulse |
| pwmOut | output | 1 | PWM output |
| pwmOe | output | 1 | Output enable (low = tristate) |
| faultActive | output | 1 | Fault state flag |
| running | output | 1 | Trigger running flag |

## Verification
The hardest situation to reach is a control or value change that lands at a chosen sub-phase relative to a period wrap. Examples are a fault released just before a wrap in each exit policy, a fault-clear strobe issued while the fault is still held, and a buffered duty write one clock before a wrap. Directed phases reach each of these cases. A long stretch of random writes, faults, syncs and triggers then follows. The bench model is compared against the outputs on every clock, so any mis-timed switch shows up in the very cycle it happens.

// File: rtl/oc_pwm_pkg.sv
package oc_pwm_pkg;

  localparam logic [1:0] ADDR_PER  = 2'd0;
  localparam logic [1:0] ADDR_DUTY = 2'd1;
  localparam logic [1:0] ADDR_FINE = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // packed MSB first: trigMode is control bit 6, pwmMode is bit 0
  typedef struct packed {
    logic trigMode;
    logic dirTri;
    logic invert;
    logic faultDrv;
    logic faultLevel;
    logic faultMode;
    logic pwmMode;
  } ocCfg_t;

  typedef struct packed {
    logic tick;
    logic hold;
    logic syncRst;
  } ocStrb_t;

endpackage

// File: rtl/oc_pwm_ctrl.sv
module oc_pwm_ctrl
  import oc_pwm_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrAddr,
  input  logic [7:0]      wrCtl,
  input  logic            faultIn,
  input  logic            faultClr,
  input  logic            syncIn,
  input  logic            trigIn,
  input  logic            periodStart,
  input  logic            cmpOut,
  output ocCfg_t          cfg,
  output ocStrb_t         strb,
  output logic [PH_W-1:0] phase,
  output logic            faultActive,
  output logic            running,
  output logic            pwmOut,
  output logic            pwmOe
);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic ctlWr;
  logic faultExit;

  assign ctlWr = wrEn && (wrAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (ctlWr) begin
      cfg <= ocCfg_t'(wrCtl[6:0]);
    end
  end

  always_comb begin
    strb.tick    = (phase == PH_LAST);
    strb.hold    = cfg.trigMode && !running;
    strb.syncRst = !cfg.trigMode && syncIn;
  end

  // sub-phase generator, realigned by sync
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (strb.syncRst) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // running flag: hardware set by trigger, software re-arm clears it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (cfg.trigMode && trigIn) begin
      running <= 1'b1;
    end else if (ctlWr && wrCtl[7]) begin
      running <= 1'b0;
    end
  end

  assign faultExit = cfg.faultMode ? faultClr : periodStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultActive <= 1'b0;
    end else if (faultIn) begin
      faultActive <= 1'b1;
    end else if (faultExit) begin
      faultActive <= 1'b0;
    end
  end

  always_comb begin
    pwmOut = faultActive ? cfg.faultLevel : cmpOut;
    if (faultActive && cfg.faultDrv) begin
      pwmOe = 1'b1;
    end else begin
      pwmOe = !cfg.dirTri;
    end
  end

endmodule

// File: rtl/oc_pwm_dp.sv
module oc_pwm_dp
  import oc_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  ocCfg_t           cfg,
  input  ocStrb_t          strb,
  input  logic [PH_W-1:0]  phase,
  output logic             periodStart,
  output logic [CNT_W-1:0] cnt,
  output logic             cmpOut
);
  logic [CNT_W-1:0] perReg, dutyReg, perSh, dutySh, perAct, dutyAct;
  logic [PH_W-1:0]  fineReg, fineSh, fineAct;
  logic             hiNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perReg  <= '0;
      dutyReg <= '0;
      fineReg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PER:  perReg  <= wrData;
        ADDR_DUTY: dutyReg <= wrData;
        ADDR_FINE: fineReg <= wrData[PH_W-1:0];
        default:   ;
      endcase
    end
  end

  // shadow copies reloaded at every wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perSh  <= '0;
      dutySh <= '0;
      fineSh <= '0;
    end else if (periodStart) begin
      perSh  <= perReg;
      dutySh <= dutyReg;
      fineSh <= fineReg;
    end
  end

  always_comb begin
    if (cfg.pwmMode) begin
      perAct  = perSh;
      dutyAct = dutySh;
      fineAct = fineSh;
    end else begin
      perAct  = perReg;
      dutyAct = dutyReg;
      fineAct = fineReg;
    end
  end

  assign periodStart = strb.tick && !strb.hold && (cnt >= perAct);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.syncRst) begin
      cnt <= '0;
    end else if (strb.tick) begin
      if (strb.hold || periodStart) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    hiNext = 1'b0;
    if (!strb.hold && (dutyAct != '0)) begin
      if (dutyAct >= perAct) begin
        hiNext = 1'b1;
      end else if (cnt < dutyAct) begin
        hiNext = 1'b1;
      end else if ((cnt == dutyAct) && (phase < fineAct)) begin
        hiNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpOut <= 1'b0;
    end else begin
      cmpOut <= hiNext ^ cfg.invert;
    end
  end

endmodule

// File: rtl/oc_pwm.sv
module oc_pwm
  import oc_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             faultIn,
  input  logic             faultClr,
  input  logic             syncIn,
  input  logic             trigIn,
  output logic             pwmOut,
  output logic             pwmOe,
  output logic             faultActive,
  output logic             running
);
  ocCfg_t           cfg;
  ocStrb_t          strb;
  logic [PH_W-1:0]  phase;
  logic             periodStart;
  logic             cmpOut;
  logic [CNT_W-1:0] timerCnt;

  oc_pwm_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCtl(wrData[7:0]),
    .faultIn(faultIn), .faultClr(faultClr), .syncIn(syncIn), .trigIn(trigIn),
    .periodStart(periodStart), .cmpOut(cmpOut), .cfg(cfg), .strb(strb),
    .phase(phase), .faultActive(faultActive), .running(running),
    .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  oc_pwm_dp #(.CNT_W(CNT_W), .PH_W(PH_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfg(cfg), .strb(strb), .phase(phase), .periodStart(periodStart),
    .cnt(timerCnt), .cmpOut(cmpOut)
  );

endmodule

// File: rtl/oc_pwm_chk.sv
module oc_pwm_chk
  import oc_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic             faultIn,
  input logic             faultClr,
  input logic             syncIn,
  input logic             trigIn,
  input logic             pwmOut,
  input logic             pwmOe,
  input logic             faultActive,
  input logic             running,
  input ocCfg_t           cfg,
  input logic             tick,
  input logic             hold,
  input logic [CNT_W-1:0] cnt
);
  logic ctlWr;
  assign ctlWr = wrEn && (wrAddr == ADDR_CTRL);

  p_fault_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |=> faultActive);

  p_fault_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultIn && !ctlWr |=> pwmOut == $past(cfg.faultLevel));

  p_fault_oe_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultIn && cfg.faultDrv && !ctlWr |=> pwmOe);

  p_ack_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultActive && cfg.faultMode && !faultClr && !ctlWr |=> faultActive);

  p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    hold && tick |=> cnt == '0);

  p_trig_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfg.trigMode && trigIn |=> running);

  p_sync_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.trigMode && syncIn |=> cnt == '0);

endmodule

bind oc_pwm oc_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .faultIn(faultIn),
  .faultClr(faultClr), .syncIn(syncIn), .trigIn(trigIn), .pwmOut(pwmOut),
  .pwmOe(pwmOe), .faultActive(faultActive), .running(running), .cfg(cfg),
  .tick(strb.tick), .hold(strb.hold), .cnt(timerCnt)
);

// File: tb/sim_oc_pwm.sv
module sim_oc_pwm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        faultIn = 1'b0, faultClr = 1'b0, syncIn = 1'b0, trigIn = 1'b0;
  logic        pwmOut, pwmOe, faultActive, running;

  int nChk = 0;
  int nBad = 0;
  string curReq = "R1";
  bit compareOn = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_pwm u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .faultIn(faultIn), .faultClr(faultClr), .syncIn(syncIn), .trigIn(trigIn),
    .pwmOut(pwmOut), .pwmOe(pwmOe), .faultActive(faultActive), .running(running)
  );

  // behavioural reference
  int mPer, mDuty, mFine, mPerS, mDutyS, mFineS, mCnt, mPh;
  bit [7:0] mCtrl;
  bit mRun, mFlt, mOut;

  always @(posedge clk) begin : model
    int pa, da, fa;
    bit held, tick, hi, roll, syncHit;
    if (!rstN) begin
      mPer = 0; mDuty = 0; mFine = 0; mPerS = 0; mDutyS = 0; mFineS = 0;
      mCnt = 0; mPh = 0; mCtrl = 0; mRun = 0; mFlt = 0; mOut = 0;
    end else begin
      pa = mCtrl[0] ? mPerS : mPer;
      da = mCtrl[0] ? mDutyS : mDuty;
      fa = mCtrl[0] ? mFineS : mFine;
      held = mCtrl[6] && !mRun;
      tick = (mPh == 3);
      hi = 0;
      if (!held && da != 0) hi = (da >= pa) || (mCnt < da) || (mCnt == da && mPh < fa);
      roll = tick && !held && (mCnt >= pa);
      syncHit = !mCtrl[6] && syncIn;
      mOut = hi ^ mCtrl[4];
      if (faultIn) mFlt = 1;
      else if (mCtrl[1] ? faultClr : roll) mFlt = 0;
      if (mCtrl[6] && trigIn) mRun = 1;
      else if (wrEn && wrAddr == 3 && wrData[7]) mRun = 0;
      if (syncHit) begin
        mCnt = 0; mPh = 0;
      end else begin
        if (tick) mCnt = (held || roll) ? 0 : mCnt + 1;
        mPh = (mPh + 1) % 4;
      end
      if (roll) begin
        mPerS = mPer; mDutyS = mDuty; mFineS = mFine;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: mPer = int'(wrData);
          2'd1: mDuty = int'(wrData);
          2'd2: mFine = int'(wrData[1:0]);
          default: mCtrl = {1'b0, wrData[6:0]};
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && compareOn && !finished) begin
      bit eOut, eOe;
      eOut = mFlt ? mCtrl[2] : mOut;
      eOe = (mFlt && mCtrl[3]) ? 1'b1 : !mCtrl[5];
      nChk++;
      if ({pwmOut, pwmOe, faultActive, running} != {eOut, eOe, mFlt, mRun}) begin
        nBad++;
        $display("FAIL %s t=%0t out/oe/flt/run actual=%b%b%b%b expected=%b%b%b%b",
                 curReq, $time, pwmOut, pwmOe, faultActive, running, eOut, eOe, mFlt, mRun);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic pulse(ref logic s, input int n);
    s = 1'b1;
    step(n);
    s = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin : main
    step(3);
    @(negedge clk);
    chk(pwmOut == 0, "R2 reset out", pwmOut, 0);
    chk(pwmOe == 1, "R9 reset oe", pwmOe, 1);
    chk(faultActive == 0, "R6 reset fault", faultActive, 0);
    chk(running == 0, "R10 reset running", running, 0);
    step(0);
    rstN = 1'b1; compareOn = 1'b1;
    step(1);

    curReq = "R1";
    wr(0, 5); wr(1, 2); step(60);
    curReq = "R3";
    for (int f = 1; f < 4; f++) begin wr(2, 16'(f)); step(30); end
    curReq = "R2";
    wr(1, 0); step(30); wr(1, 5); step(30); wr(1, 9); step(30); wr(1, 3); step(30);

    curReq = "R4";
    wr(3, 16'h0001); step(13);
    wr(1, 1); step(50); wr(2, 0); step(7); wr(0, 7); wr(1, 6); step(90);

    curReq = "R5";
    wr(3, 16'h0011); step(50);

    curReq = "R7";
    wr(3, 16'h0005); step(5);
    pulse(faultIn, 3);
    @(negedge clk);
    chk(faultActive == 1, "R6 fault latched", faultActive, 1);
    chk(pwmOut == 1, "R6 fault level", pwmOut, 1);
    step(70);

    curReq = "R8";
    wr(3, 16'h0003);
    faultIn = 1'b1; step(4);
    pulse(faultClr, 1);
    faultIn = 1'b0; step(40);
    @(negedge clk);
    chk(faultActive == 1, "R8 held without ack", faultActive, 1);
    step(0);
    pulse(faultClr, 1);
    @(negedge clk);
    chk(faultActive == 0, "R8 ack clears", faultActive, 0);
    step(20);

    curReq = "R9";
    wr(3, 16'h0021);
    @(negedge clk);
    chk(pwmOe == 0, "R9 tristate", pwmOe, 0);
    step(0);
    pulse(faultIn, 2); step(30);
    wr(3, 16'h0029);
    pulse(faultIn, 2);
    @(negedge clk);
    chk(pwmOe == 1, "R9 fault drives pin", pwmOe, 1);
    step(40);

    curReq = "R10";
    wr(3, 16'h0041); step(40);
    @(negedge clk);
    chk(running == 0, "R10 waiting", running, 0);
    chk(pwmOut == 0, "R10 held low", pwmOut, 0);
    step(0);
    pulse(trigIn, 1);
    @(negedge clk);
    chk(running == 1, "R10 triggered", running, 1);
    step(60);

    curReq = "R11";
    wr(3, 16'h00C1);
    @(negedge clk);
    chk(running == 0, "R11 rearm", running, 0);
    step(20);
    trigIn = 1'b1; wr(3, 16'h00C1); trigIn = 1'b0;
    @(negedge clk);
    chk(running == 1, "R11 trigger wins", running, 1);
    step(20);

    curReq = "R12";
    wr(3, 16'h0001); step(9);
    pulse(syncIn, 1); step(14); pulse(syncIn, 1); step(3); pulse(syncIn, 1); step(40);

    curReq = "R1 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      faultIn = ($urandom_range(0, 39) == 0);
      faultClr = ($urandom_range(0, 19) == 0);
      syncIn = ($urandom_range(0, 49) == 0);
      trigIn = ($urandom_range(0, 29) == 0);
      if (r < 4) begin
        wrEn = 1'b1; wrAddr = 2'($urandom_range(0, 3));
        wrData = (wrAddr == 3) ? 16'($urandom_range(0, 255)) : 16'($urandom_range(0, 9));
      end else begin
        wrEn = 1'b0;
      end
      step(1);
    end
    wrEn = 1'b0; faultIn = 1'b0; faultClr = 1'b0; syncIn = 1'b0; trigIn = 1'b0;
    step(5);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule